// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a small serial non-volatile memory holding 64 words of 16 bits. A host talks to it over three wires and a select line: a select input, a shift clock, a serial data input and a serial data output. The host raises select, clocks in a start bit, a two-bit opcode and a six-bit word address (most significant bit first, sampled on rising shift-clock edges), and then either clocks data in or receives data out. The serial inputs are oversampled by a faster system clock, so the model sits inside a single clock domain.

Writes only take effect once the host has put the block into a persistent write-enabled state. A write overwrites the addressed word directly, with no erase step first. It then runs as a timed busy period whose length is a parameter in system clock cycles. While that period runs, the block ignores new frames. When the host raises select again after a write has started, the data output reports ready/busy: low while the write is in progress, high once it has finished. The output is modelled as a data bit plus an output-enable, and the enable is low whenever the block is deselected.

Top module: `wire3_eeprom`

## Requirements
- R1: After reset the output-enable is low, the write-enabled state is cleared and every word reads back as 0.
- R2: A frame of start bit 1, opcode 10 and a 6-bit address drives a dummy 0 after the last address bit, then the 16 bits of the addressed word MSB first, each updated after a rising shift-clock edge; 0 bits on the data input before the start bit are ignored.
- R3: Opcode 00 with address bits [5:4] = 11 sets the write-enabled state and opcode 00 with address bits [5:4] = 00 clears it; the state persists across frames until cleared or reset.
- R4: A frame of start bit, opcode 01, address and exactly 16 data bits (MSB first), sent while write-enabled, replaces the addressed word when select falls.
- R5: A write frame sent while the write-enabled state is clear changes no word and starts no busy period.
- R6: A write frame with 15 or 17 data bits is discarded: no word changes and no busy period starts.
- R7: After a write has started, raising select enables the output, which reads 0 while busy and 1 once WR_CYCLES system cycles of busy have elapsed.
- R8: Any frame sent while a write is busy is ignored, so a write frame sent then leaves its word unchanged.
- R9: The output-enable is low whenever select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| shclk | input | 1 | Serial shift clock; rising edges sample the data input |
| sdin | input | 1 | Serial data input |
| sdout | output | 1 | Serial data output (read data or ready/busy flag) |
| sdout_oe | output | 1 | Output-enable for sdout; low means high-impedance |

## Verification
The hardest situation to reach is a complete frame arriving while a write is still busy, because a frame lasts hundreds of system cycles and the busy window must outlast it. The bench starts a write, reselects the block within a few cycles and clocks a full write frame to a neighbouring address before the busy period ends. It then waits for ready and reads both words back. The same ready/busy polling measures the busy length from the deselect edge against WR_CYCLES.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_HDR   = 3'd1,
        S_READ  = 3'd2,
        S_WDATA = 3'd3,
        S_SKIP  = 3'd4
    } fsm_t;

    localparam logic [1:0] OP_CTL  = 2'b00;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;

    localparam logic [1:0] CTL_ON  = 2'b11;
    localparam logic [1:0] CTL_OFF = 2'b00;

endpackage

// File: rtl/eep_sync.sv
module eep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic shclk,
    input  logic sdin,
    output logic sel_s,
    output logic sel_fall,
    output logic sk_rise,
    output logic din_s
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic sp;
        logic k1;
        logic k2;
        logic kp;
        logic d1;
        logic d2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = sel;
        d.s2 = q.s1;
        d.sp = q.s2;
        d.k1 = shclk;
        d.k2 = q.k1;
        d.kp = q.k2;
        d.d1 = sdin;
        d.d2 = q.d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sel_s    = q.s2;
    assign sel_fall = q.sp & ~q.s2;
    assign sk_rise  = q.k2 & ~q.kp;
    assign din_s    = q.d2;

endmodule

// File: rtl/eep_timer.sv
module eep_timer #(
    parameter int WR_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(WR_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] mem_d [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++)
            mem_d[i] = mem_q[i];
        if (we)
            mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++)
                mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++)
                mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              sel_fall,
    input  logic              sk_rise,
    input  logic              din_s,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_go,
    output logic              wen,
    output logic              sdout,
    output logic              sdout_oe
);

    localparam int HDR_W = 2 + ADDR_W;
    localparam int MAXB  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 2);

    typedef struct packed {
        fsm_t              st;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  hdr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] sh;
        logic              wen;
        logic              stat;
        logic              dout;
        logic              oe;
    } ctl_t;

    ctl_t q, d;

    logic [HDR_W-1:0]  hdr_nx;
    logic [1:0]        op_nx;
    logic [ADDR_W-1:0] adr_nx;
    logic [DATA_W-1:0] rd_src;

    always_comb begin
        hdr_nx = {q.hdr[HDR_W-2:0], din_s};
        op_nx  = hdr_nx[HDR_W-1 -: 2];
        adr_nx = hdr_nx[ADDR_W-1:0];
        rd_src = (q.cnt == '0) ? rd_data : q.sh;
        d      = q;
        wr_go  = 1'b0;

        if (!sel_s) begin
            d.st   = S_IDLE;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.dout = 1'b0;
            if (sel_fall && q.st == S_WDATA && q.cnt == CNT_W'(DATA_W)
                && q.wen && !busy) begin
                wr_go  = 1'b1;
                d.stat = 1'b1;
            end
        end else begin
            unique case (q.st)
                S_IDLE: begin
                    d.oe   = q.stat;
                    d.dout = ~busy;
                    if (sk_rise && din_s && !busy) begin
                        d.st   = S_HDR;
                        d.cnt  = '0;
                        d.stat = 1'b0;
                        d.oe   = 1'b0;
                        d.dout = 1'b0;
                    end
                end
                S_HDR: begin
                    if (sk_rise) begin
                        d.hdr = hdr_nx;
                        if (q.cnt == CNT_W'(HDR_W - 1)) begin
                            d.addr = adr_nx;
                            d.cnt  = '0;
                            d.st   = S_SKIP;
                            if (op_nx == OP_RD) begin
                                d.st   = S_READ;
                                d.oe   = 1'b1;
                                d.dout = 1'b0;
                            end else if (op_nx == OP_WR) begin
                                d.st = S_WDATA;
                            end else if (op_nx == OP_CTL) begin
                                if (adr_nx[ADDR_W-1 -: 2] == CTL_ON)
                                    d.wen = 1'b1;
                                else if (adr_nx[ADDR_W-1 -: 2] == CTL_OFF)
                                    d.wen = 1'b0;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                S_READ: begin
                    d.oe = 1'b1;
                    if (sk_rise) begin
                        d.dout = rd_src[DATA_W-1];
                        d.sh   = {rd_src[DATA_W-2:0], 1'b0};
                        d.cnt  = CNT_W'(1);
                    end
                end
                S_WDATA: begin
                    if (sk_rise) begin
                        d.sh = {q.sh[DATA_W-2:0], din_s};
                        if (q.cnt <= CNT_W'(DATA_W))
                            d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign addr     = q.addr;
    assign wr_data  = q.sh;
    assign wen      = q.wen;
    assign sdout    = q.dout;
    assign sdout_oe = q.oe;

endmodule

// File: rtl/wire3_eeprom.sv
module wire3_eeprom #(
    parameter int WORDS     = 64,
    parameter int DATA_W    = 16,
    parameter int WR_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic shclk,
    input  logic sdin,
    output logic sdout,
    output logic sdout_oe
);

    localparam int ADDR_W = $clog2(WORDS);

    logic              sel_s, sel_fall, sk_rise, din_s;
    logic              busy, wr_go, wen;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    eep_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .shclk    (shclk),
        .sdin     (sdin),
        .sel_s    (sel_s),
        .sel_fall (sel_fall),
        .sk_rise  (sk_rise),
        .din_s    (din_s)
    );

    eep_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s    (sel_s),
        .sel_fall (sel_fall),
        .sk_rise  (sk_rise),
        .din_s    (din_s),
        .busy     (busy),
        .rd_data  (rd_data),
        .addr     (addr),
        .wr_data  (wr_data),
        .wr_go    (wr_go),
        .wen      (wen),
        .sdout    (sdout),
        .sdout_oe (sdout_oe)
    );

    eep_array #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_go),
        .waddr (addr),
        .wdata (wr_data),
        .raddr (addr),
        .rdata (rd_data)
    );

    eep_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_go),
        .busy  (busy)
    );

endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
    parameter int WR_CYCLES = 500
) (
    input logic clk,
    input logic rst_n,
    input logic sel_s,
    input logic sdout_oe,
    input logic busy,
    input logic wr_go,
    input logic wen
);

    int unsigned bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= 0;
    end

    p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !sdout_oe);

    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == WR_CYCLES));

    p_go_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> wen);

    p_go_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !busy);

    p_go_starts_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> busy);

    p_go_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !sel_s);

endmodule

bind wire3_eeprom eep_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_s    (sel_s),
    .sdout_oe (sdout_oe),
    .busy     (busy),
    .wr_go    (wr_go),
    .wen      (wen)
);

// File: tb/tb_wire3_eeprom.sv
module tb_wire3_eeprom;

    localparam int WRC = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic shclk = 1'b0;
    logic sdin = 1'b0;
    logic sdout, sdout_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int t_fall = 0;
    bit done = 0;

    logic [15:0] model [64];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wire3_eeprom #(.WORDS(64), .DATA_W(16), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .shclk(shclk), .sdin(sdin),
        .sdout(sdout), .sdout_oe(sdout_oe)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h3b1d + 16'h7e41) ^ (a << 10));
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        sdin = b;
        clks(6);
        shclk = 1'b1;
        clks(6);
        shclk = 1'b0;
    endtask

    task automatic send_frame(input logic [1:0] op, input logic [5:0] a,
                              input logic [15:0] dw, input int nd, input int lead);
        sel = 1'b1;
        clks(4);
        for (int i = 0; i < lead; i++) sk_bit(1'b0);
        sk_bit(1'b1);
        sk_bit(op[1]);
        sk_bit(op[0]);
        for (int i = 5; i >= 0; i--) sk_bit(a[i]);
        for (int i = 0; i < nd; i++) sk_bit(i < 16 ? dw[15-i] : 1'b0);
        clks(2);
        sel = 1'b0;
        t_fall = cyc;
        clks(6);
    endtask

    task automatic read_word(input logic [5:0] a, input int lead,
                             output logic [15:0] w, output bit ok);
        sel = 1'b1;
        clks(4);
        for (int i = 0; i < lead; i++) sk_bit(1'b0);
        sk_bit(1'b1);
        sk_bit(1'b1);
        sk_bit(1'b0);
        for (int i = 5; i >= 0; i--) sk_bit(a[i]);
        ok = (sdout_oe === 1'b1) && (sdout === 1'b0);
        for (int i = 0; i < 16; i++) begin
            sk_bit(1'b0);
            w[15-i] = sdout;
            ok = ok && (sdout_oe === 1'b1);
        end
        sel = 1'b0;
        clks(6);
    endtask

    task automatic check_read(input logic [5:0] a, input int lead, input string req);
        logic [15:0] w;
        bit ok;
        read_word(a, lead, w, ok);
        check(ok && (w === model[a]), req, {15'd0, ok, w}, {16'h0001, model[a]});
    endtask

    task automatic wait_ready(input string req);
        int el;
        sel = 1'b1;
        clks(5);
        check(sdout_oe === 1'b1 && sdout === 1'b0, req,
              {30'd0, sdout_oe, sdout}, 32'h2);
        for (int k = 0; k < 4 * WRC && sdout !== 1'b1; k++) clks(1);
        el = cyc - t_fall;
        check(sdout_oe === 1'b1 && sdout === 1'b1 && el >= WRC && el <= WRC + 20,
              req, el, WRC);
        sel = 1'b0;
        clks(4);
    endtask

    task automatic check_no_status(input string req);
        sel = 1'b1;
        clks(6);
        check(sdout_oe === 1'b0, req, {31'd0, sdout_oe}, 32'h0);
        sel = 1'b0;
        clks(4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] old21;
        for (int i = 0; i < 64; i++) model[i] = 16'h0000;
        clks(4);
        rst_n = 1'b1;
        clks(4);

        // R1: reset state
        check(sdout_oe === 1'b0, "R1 oe after reset", {31'd0, sdout_oe}, 32'h0);
        check_read(6'd5, 0, "R1 R2 read after reset");
        check_read(6'd63, 0, "R1 R2 read top after reset");

        // R5 and R1: write before any enable is ignored
        send_frame(2'b01, 6'd3, 16'h1234, 16, 0);
        check_no_status("R5 no busy when disabled");
        check_read(6'd3, 0, "R5 word unchanged");

        // R3: enable, R9 output off while deselected
        send_frame(2'b00, 6'b110000, 16'h0, 0, 0);
        clks(3);
        check(sdout_oe === 1'b0, "R9 oe low deselected", {31'd0, sdout_oe}, 32'h0);

        // R4 R7 R3: sweep all addresses; enable persists across writes
        for (int a = 0; a < 64; a++) begin
            send_frame(2'b01, 6'(a), pat(a), 16, (a % 2) * 2);
            model[a] = pat(a);
            wait_ready("R7 ready/busy");
        end
        // R2 R4: read back every word, some with leading zeros
        for (int a = 0; a < 64; a++)
            check_read(6'(a), (a % 3), "R2 R4 sweep readback");
        clks(3);
        check(sdout_oe === 1'b0, "R9 oe low after read", {31'd0, sdout_oe}, 32'h0);

        // R6: too many / too few data bits
        send_frame(2'b01, 6'd10, 16'hdead, 17, 0);
        check_no_status("R6 17 bits no busy");
        check_read(6'd10, 0, "R6 17 bits word unchanged");
        send_frame(2'b01, 6'd10, 16'hbeef, 15, 0);
        check_no_status("R6 15 bits no busy");
        check_read(6'd10, 0, "R6 15 bits word unchanged");

        // R8: write frame during busy period is ignored
        old21 = model[21];
        send_frame(2'b01, 6'd20, 16'hc3a5, 16, 0);
        model[20] = 16'hc3a5;
        begin
            int tf;
            tf = t_fall;
            send_frame(2'b01, 6'd21, 16'h0f0f, 16, 0);
            t_fall = tf;
        end
        wait_ready("R8 R7 busy window");
        check_read(6'd20, 0, "R8 first write landed");
        check_read(6'd21, 0, "R8 busy frame ignored");
        check(model[21] === old21, "R8 model", model[21], old21);

        // R3: disable, then writes are ignored; enable again restores them
        send_frame(2'b00, 6'b001111, 16'h0, 0, 0);
        send_frame(2'b01, 6'd30, 16'h5555, 16, 0);
        check_no_status("R3 disabled no busy");
        check_read(6'd30, 0, "R3 disabled word unchanged");
        send_frame(2'b00, 6'b111111, 16'h0, 0, 0);
        send_frame(2'b01, 6'd30, 16'h5555, 16, 1);
        model[30] = 16'h5555;
        wait_ready("R3 R7 re-enabled write");
        check_read(6'd30, 0, "R3 re-enabled write landed");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule